// File: doc/BRIEF.md
# Real/Complex Sample Word Packer

This block packs a stream of digitized samples into 64-bit storage words for a downstream FIFO. Each incoming sample carries an in-phase (I) and a quadrature (Q) component, 32 bits each. Two run-time configuration inputs choose whether only the real (I) part is kept or the full complex pair, and whether each kept component is stored at 32 bits or reduced to its upper 16 bits. Depending on the combination, a single sample takes 2, 4 or 8 bytes, so between one and four samples share one output word.

Both data interfaces are valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. Once the output word is valid, it stays valid and unchanged until the downstream side accepts it. While a word is held and not yet accepted, the block drops input ready, so upstream back-pressure follows downstream back-pressure in the same cycle. A flush input pushes out a partly filled word at the end of a capture, with the lanes that were not filled set to zero.

The configuration inputs are sampled only while no partial word is held. They set the layout of the whole word that the next accepted sample opens.

Top module: `sample_packer`

## Requirements
- R1: Real 16-bit mode (`cplx_i`=0, `wide_i`=0): four samples form one word, and each sample contributes bits [31:16] of `s_i` as a 16-bit lane.
- R2: Real 32-bit mode (`cplx_i`=0, `wide_i`=1): two samples form one word, and each sample contributes all 32 bits of `s_i` as a lane.
- R3: Complex 16-bit mode (`cplx_i`=1, `wide_i`=0): two samples form one word. Each sample makes a 32-bit lane with `s_i`[31:16] in its lower half and `s_q`[31:16] in its upper half.
- R4: Complex 32-bit mode (`cplx_i`=1, `wide_i`=1): every sample forms one whole word `{s_q, s_i}`. It appears on `m_data` with `m_valid` high in the cycle after it is accepted.
- R5: Within a word, the earliest sample sits in the least-significant lane, and each later sample takes the next higher lane.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high, `m_data` stays unchanged, and `s_ready` is low.
- R7: While `flush_i` is high, `s_ready` is low. If a partial word is held and the output slot is free, that word is emitted with its unfilled lanes zero, and the lane count restarts. With no partial word held, flush emits nothing.
- R8: `cplx_i` and `wide_i` take effect only when a sample is accepted with no partial word held. A change while a word is partly filled does not alter that word's layout.
- R9: After reset, `m_valid` is low, `s_ready` is high, and no partial word is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cplx_i | input | 1 | 1 keeps I and Q, 0 keeps only I |
| wide_i | input | 1 | 1 stores 32-bit components, 0 stores the upper 16 bits |
| flush_i | input | 1 | Emit the partial word (level, blocks input while high) |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample ready |
| s_i | input | 32 | In-phase component |
| s_q | input | 32 | Quadrature component |
| m_valid | output | 1 | Packed word valid |
| m_ready | input | 1 | Downstream ready for packed word |
| m_data | output | 64 | Packed word |

## Verification
Directed sequences run each of the four layouts on its own with distinct values in every lane. They pin down lane order and the choice of upper component halves, and they show which half of a complex lane carries I and which carries Q. A flush after a single complex 16-bit sample shows the zero fill, and a flush with nothing held shows that no word appears. A configuration change in the middle of a real 32-bit word shows whether the word's layout is locked. A long random run then changes the modes, stalls the output, and raises flush at arbitrary points. This stresses the lane counter across mode boundaries and checks that output stalls correctly hold back input while every word keeps its contents.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef struct packed {
    logic cplx;
    logic wide;
  } fmt_t;

  // samples held by one 64-bit word in each layout
  function automatic logic [2:0] per_word(fmt_t f);
    case ({f.cplx, f.wide})
      2'b00:   return 3'd4;
      2'b01:   return 3'd2;
      2'b10:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/sp_extract.sv
module sp_extract #(
  parameter int COMP_W = 32,
  parameter int WORD_W = 64,
  parameter int OFF_W  = 7
) (
  input  sp_pkg::fmt_t        fmt,
  input  logic [COMP_W-1:0]   comp_i,
  input  logic [COMP_W-1:0]   comp_q,
  output logic [WORD_W-1:0]   chunk,
  output logic [OFF_W-1:0]    lane_w
);
  localparam int HALF_W = COMP_W / 2;

  logic [HALF_W-1:0] i_hi, q_hi;
  assign i_hi = comp_i[COMP_W-1 -: HALF_W];
  assign q_hi = comp_q[COMP_W-1 -: HALF_W];

  always_comb begin
    chunk  = '0;
    lane_w = '0;
    case ({fmt.cplx, fmt.wide})
      2'b00: begin
        chunk[HALF_W-1:0] = i_hi;
        lane_w = OFF_W'(HALF_W);
      end
      2'b01: begin
        chunk[COMP_W-1:0] = comp_i;
        lane_w = OFF_W'(COMP_W);
      end
      2'b10: begin
        chunk[COMP_W-1:0] = {q_hi, i_hi};
        lane_w = OFF_W'(COMP_W);
      end
      default: begin
        chunk[2*COMP_W-1:0] = {comp_q, comp_i};
        lane_w = OFF_W'(2 * COMP_W);
      end
    endcase
  end
endmodule

// File: rtl/sp_accum.sv
module sp_accum #(
  parameter int WORD_W = 64,
  parameter int OFF_W  = 7,
  parameter int FILL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              flush_go,
  input  logic [WORD_W-1:0] chunk,
  input  logic [OFF_W-1:0]  lane_w,
  input  logic [2:0]        per_word,
  output logic [FILL_W-1:0] fill,
  output logic              emit,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] acc, acc_nxt;
  logic [OFF_W-1:0]  offset;
  logic              done;

  assign offset  = OFF_W'(fill) * lane_w;
  assign acc_nxt = acc | (chunk << offset);
  assign done    = push && ((FILL_W'(fill) + FILL_W'(1)) == FILL_W'(per_word));
  assign emit    = done || flush_go;
  assign word    = push ? acc_nxt : acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      fill <= '0;
    end else if (emit) begin
      acc  <= '0;
      fill <= '0;
    end else if (push) begin
      acc  <= acc_nxt;
      fill <= fill + FILL_W'(1);
    end
  end
endmodule

// File: rtl/sp_out_stage.sv
module sp_out_stage #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [WORD_W-1:0] m_data,
  output logic              busy
);
  assign busy = m_valid && !m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= din;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_packer.sv
module sample_packer #(
  parameter int COMP_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cplx_i,
  input  logic                wide_i,
  input  logic                flush_i,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [COMP_W-1:0]   s_i,
  input  logic [COMP_W-1:0]   s_q,
  output logic                m_valid,
  input  logic                m_ready,
  output logic [2*COMP_W-1:0] m_data
);
  localparam int WORD_W  = 2 * COMP_W;
  localparam int MAX_PER = WORD_W / (COMP_W / 2);
  localparam int FILL_W  = $clog2(MAX_PER + 1);
  localparam int OFF_W   = $clog2(WORD_W) + 1;

  sp_pkg::fmt_t      fmt_q, eff_fmt;
  logic [FILL_W-1:0] fill;
  logic [WORD_W-1:0] chunk, word;
  logic [OFF_W-1:0]  lane_w;
  logic              push, flush_go, emit, busy;

  // layout locked while a partial word is held
  assign eff_fmt  = (fill == '0) ? sp_pkg::fmt_t'({cplx_i, wide_i}) : fmt_q;
  assign s_ready  = !flush_i && !busy;
  assign push     = s_valid && s_ready;
  assign flush_go = flush_i && !busy && (fill != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          fmt_q <= '0;
    else if (fill == '0) fmt_q <= eff_fmt;
  end

  sp_extract #(.COMP_W(COMP_W), .WORD_W(WORD_W), .OFF_W(OFF_W)) u_ext (
    .fmt(eff_fmt), .comp_i(s_i), .comp_q(s_q), .chunk(chunk), .lane_w(lane_w)
  );

  sp_accum #(.WORD_W(WORD_W), .OFF_W(OFF_W), .FILL_W(FILL_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .push(push), .flush_go(flush_go), .chunk(chunk),
    .lane_w(lane_w), .per_word(sp_pkg::per_word(eff_fmt)), .fill(fill),
    .emit(emit), .word(word)
  );

  sp_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .din(word), .m_ready(m_ready),
    .m_valid(m_valid), .m_data(m_data), .busy(busy)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         s_valid,
  input logic         s_ready,
  input logic [31:0]  s_i,
  input logic [31:0]  s_q,
  input logic         flush_i,
  input logic         m_valid,
  input logic         m_ready,
  input logic [63:0]  m_data,
  input logic [2:0]   fill,
  input sp_pkg::fmt_t eff
);
  // R6
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R4
  full_complex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && eff.cplx && eff.wide) |=>
      (m_valid && m_data == {$past(s_q), $past(s_i)}));

  // R7
  flush_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && fill != 3'd0 && !(m_valid && !m_ready)) |=> (m_valid && fill == 3'd0));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && fill == 3'd0) |=> (!$rose(m_valid) && fill == 3'd0));

  // R8
  mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != 3'd0) |-> (eff == $past(eff)));

  // R1
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill < sp_pkg::per_word(eff) || fill == 3'd0);
endmodule

bind sample_packer sp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i),
  .s_q(s_q), .flush_i(flush_i), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .fill(fill), .eff(eff_fmt)
);

// File: tb/sample_packer_tb.sv
`timescale 1ns/1ps
module sample_packer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cplx_i = 1'b0, wide_i = 1'b0, flush_i = 1'b0, s_valid = 1'b0, m_ready = 1'b0;
  logic [31:0] s_i = '0, s_q = '0;
  logic s_ready, m_valid;
  logic [63:0] m_data;

  always #2.5 clk = ~clk;

  sample_packer u_dut (
    .clk(clk), .rst_n(rst_n), .cplx_i(cplx_i), .wide_i(wide_i), .flush_i(flush_i),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  bit [63:0] macc = '0;
  int        mfill = 0;
  bit        mc = 0, mw = 0;
  bit [63:0] qw[$];
  string     qt[$];
  bit        prev_hold = 0;
  bit [63:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string mode_tag(bit c, bit w);
    if (!c && !w) return "R1";
    if (!c && w)  return "R2";
    if (c && !w)  return "R3";
    return "R4";
  endfunction

  // one cycle: drive at negedge, evaluate, transfer at following posedge
  task automatic cyc(input bit v, input [31:0] i, input [31:0] q, input bit c, input bit w,
                     input bit f, input bit rdy, input string tag);
    bit exp_rdy, acc_ok;
    int b, spw;
    bit [63:0] ch;
    @(negedge clk);
    s_valid = v; s_i = i; s_q = q; cplx_i = c; wide_i = w; flush_i = f; m_ready = rdy;
    #1;
    exp_rdy = !f && !(m_valid && !rdy);
    chk(s_ready == exp_rdy, f ? "R7 s_ready" : "R6 s_ready", 64'(s_ready), 64'(exp_rdy));
    if (prev_hold)
      chk(m_valid && m_data == prev_data, "R6 hold", m_data, prev_data);
    if (m_valid && rdy) begin
      if (qw.size() == 0) chk(1'b0, "R7 unexpected word", m_data, 64'h0);
      else begin
        string t;
        bit [63:0] e;
        e = qw.pop_front(); t = qt.pop_front();
        chk(m_data == e, t, m_data, e);
      end
    end
    prev_hold = m_valid && !rdy;
    prev_data = m_data;
    acc_ok = v && exp_rdy;
    if (f && !(m_valid && !rdy) && mfill != 0) begin
      qw.push_back(macc); qt.push_back("R7 flush");
      macc = '0; mfill = 0;
    end
    if (acc_ok) begin
      if (mfill == 0) begin mc = c; mw = w; end
      b   = mc ? (mw ? 64 : 32) : (mw ? 32 : 16);
      spw = 64 / b;
      ch  = mc ? (mw ? {q, i} : {32'h0, q[31:16], i[31:16]}) : (mw ? {32'h0, i} : {48'h0, i[31:16]});
      macc |= ch << (mfill * b);
      mfill++;
      if (mfill == spw) begin
        qw.push_back(macc);
        qt.push_back(tag != "" ? tag : mode_tag(mc, mw));
        macc = '0; mfill = 0;
      end
    end
  endtask

  initial begin
    #(5ns * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 64'h0, 64'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 reset state
    chk(m_valid == 1'b0, "R9 m_valid", 64'(m_valid), 64'h0);
    chk(s_ready == 1'b1, "R9 s_ready", 64'(s_ready), 64'h1);

    // R1/R5: four real 16-bit samples, earliest in lowest lane
    cyc(1, 32'h1111_0aaa, 32'h9999_0000, 0, 0, 0, 0, "R1");
    cyc(1, 32'h2222_0bbb, 32'h9999_0000, 0, 0, 0, 0, "R1");
    cyc(1, 32'h3333_0ccc, 32'h9999_0000, 0, 0, 0, 0, "R1");
    cyc(1, 32'h4444_0ddd, 32'h9999_0000, 0, 0, 0, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, 0, "");
    chk(m_data == 64'h4444_3333_2222_1111, "R5 lane order", m_data, 64'h4444_3333_2222_1111);
    cyc(0, 0, 0, 0, 0, 0, 0, "");          // R6 held with m_ready low
    cyc(0, 0, 0, 0, 0, 0, 1, "");
    // R2
    cyc(1, 32'hdead_beef, 32'h0, 0, 1, 0, 1, "R2");
    cyc(1, 32'hcafe_f00d, 32'h0, 0, 1, 0, 1, "R2");
    // R3
    cyc(1, 32'h1234_5678, 32'habcd_ef01, 1, 0, 0, 1, "R3");
    cyc(1, 32'h5555_6666, 32'h7777_8888, 1, 0, 0, 1, "R3");
    // R4
    cyc(1, 32'h0102_0304, 32'h0506_0708, 1, 1, 0, 1, "R4");
    cyc(1, 32'h1112_1314, 32'h1516_1718, 1, 1, 0, 1, "R4");
    // R7: partial complex 16-bit word flushed, then flush with nothing held
    cyc(1, 32'hfeed_0001, 32'hbead_0002, 1, 0, 0, 1, "R3");
    cyc(0, 0, 0, 1, 0, 1, 1, "");
    cyc(1, 0, 0, 0, 0, 1, 1, "");
    cyc(0, 0, 0, 0, 0, 0, 1, "");
    cyc(0, 0, 0, 0, 0, 0, 1, "");
    // R8: mode change in the middle of a real 32-bit word
    cyc(1, 32'haaaa_0001, 32'h0, 0, 1, 0, 1, "R8");
    cyc(1, 32'hbbbb_0002, 32'hcccc_0003, 1, 1, 0, 1, "R8");
    cyc(0, 0, 0, 0, 0, 0, 1, "");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      bit v, c, w, f, r;
      v = ($urandom % 10) < 7;
      c = $urandom % 2;
      w = $urandom % 2;
      f = ($urandom % 20) == 0;
      r = ($urandom % 10) < 6;
      cyc(v, $urandom, $urandom, c, w, f, r, "");
    end
    // drain
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 1, 1, "");
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 0, 1, "");
    chk(qw.size() == 0, "R7 drained", 64'(qw.size()), 64'h0);
    chk(m_valid == 1'b0, "R6 idle", 64'(m_valid), 64'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule